// File: doc/BRIEF.md
# Compare-Match Toggle Square Generator

The block makes square waves from one free-running counter shared by several output channels. Each channel keeps a compare register. When the shared counter reaches that value on a counting cycle, the channel inverts its output pin and sets a sticky event flag. It then moves its compare value forward by a programmable increment. The increment equals half of the wanted output period, counted in counter ticks. The addition wraps at the counter width, so a wave keeps its rhythm when the counter rolls over, and no rearming is needed.

In the intended use, channel 0 makes an audio tone and channel 1 makes the clock for a switched-capacitor lowpass filter. The filter clock runs 125 times faster than the tone. For example, with a 488 ns tick a 400 Hz tone uses increments 2562 and 20, and a 600 Hz tone uses 1708 and 14. Software picks a new note by changing the increments at run time.

Software loads a compare register one byte at a time through a shared byte port. It writes the low byte first. Matching on that channel pauses from the low-byte write until the high-byte write, so a register that is only half updated can never cause a toggle.

Top module: `cmp_toggle_gen`

## Requirements
- R1: `cnt_o` is 0 after reset. It rises by one on each clock edge that sees `tick_i` high, and it holds when `tick_i` is low. It wraps from 0xFFFF to 0x0000 and keeps counting.
- R2: A channel matches when all of these hold at a clock edge: `tick_i` is high, its enable is high, it is not locked by a pending byte write, it has no byte write strobe in that cycle, and `cnt_o` equals its compare value. On that edge its `wave_o` bit inverts. In no other case does `wave_o` change, except by reset.
- R3: On a match, the compare value becomes (compare + increment) mod 2^16. The next toggle therefore comes exactly `increment` ticks later, across counter wrap too. Channel c takes its increment from `incr_i[16*c +: 16]`.
- R4: The increment is sampled only at a match. Changing `incr_i` between matches does not move the toggle that is already scheduled.
- R5: A match sets the channel's `flag_o` bit. The bit stays set until `flag_clr_i` for that channel is high at a clock edge with no match. A match and a clear at the same edge leave the flag set.
- R6: While a channel's `en_i` bit is low, its output holds its level, its flag is not set and its compare value does not advance.
- R7: `wr_lo_i[c]` loads `wr_data_i` into bits 7:0 of channel c's compare value and locks matching on that channel. `wr_hi_i[c]` loads `wr_data_i` into bits 15:8 and unlocks it. Channels are independent.
- R8: Reset (`rst_ni` low, asynchronous) clears the counter, all flags, all outputs and all locks. Compare values are not reset.
- R9: While `tick_i` is low, the counter value is held and no match is taken. A counter value held for many cycles therefore gives exactly one toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler strobe; advances the counter and enables matching |
| en_i | input | N_CH | Per-channel enable |
| incr_i | input | N_CH*CNT_W | Per-channel half-period increment, channel c at [CNT_W*c +: CNT_W] |
| wr_lo_i | input | N_CH | Low-byte compare write strobe |
| wr_hi_i | input | N_CH | High-byte compare write strobe |
| wr_data_i | input | 8 | Shared write byte |
| flag_clr_i | input | N_CH | Per-channel flag clear |
| cnt_o | output | CNT_W | Shared counter value |
| wave_o | output | N_CH | Square-wave outputs |
| flag_o | output | N_CH | Sticky match flags |

## Verification
On every cycle, the assertions check the local rules. The counter rolls over and holds when it should. An output changes only on a counting, enabled cycle. An output never changes while its channel is locked. A flag stays set until it is cleared. Other behaviours show only in the bench scenarios, which compare every cycle against an independent model. These cover toggle spacing that follows the increment across counter and compare wrap, and the 125:1 ratio between the tone and filter-clock rates. They also cover an increment change that does not disturb the pending half-period, and a low byte followed by a high byte written while the counter passes the old compare value.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic lo;
    logic hi;
  } byte_wr_t;
endpackage

// File: rtl/cmp_free_counter.sv
module cmp_free_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R1
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == {W{1'b1}}) |=> (cnt_q == '0));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [W-1:0]      cnt_i,
  input  logic              en_i,
  input  logic [W-1:0]      incr_i,
  input  byte_wr_t          wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic              wave_o,
  output logic              flag_o
);
  localparam int unsigned HI_W = W - BYTE_W;

  logic [W-1:0] cmp_q;
  logic         wave_q, flag_q, lock_q;
  logic         wr_any, hit;

  assign wr_any = wr_i.lo | wr_i.hi;
  assign hit    = tick_i & en_i & ~lock_q & ~wr_any & (cnt_i == cmp_q);

  // compare value deliberately has no reset
  always_ff @(posedge clk_i) begin
    if (wr_any) begin
      if (wr_i.lo) cmp_q[BYTE_W-1:0] <= wr_data_i;
      if (wr_i.hi) cmp_q[W-1:BYTE_W] <= wr_data_i[HI_W-1:0];
    end else if (hit) begin
      cmp_q <= cmp_q + incr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i.hi)      lock_q <= 1'b0;
      else if (wr_i.lo) lock_q <= 1'b1;
      if (hit) begin
        wave_q <= ~wave_q;
        flag_q <= 1'b1;
      end else if (flag_clr_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign wave_o = wave_q;
  assign flag_o = flag_q;

  // R2
  wave_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i || !en_i) |=> $stable(wave_q));
  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(wave_q));
  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  // R5
  toggle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_q != $past(wave_q)) |-> flag_q);
endmodule

// File: rtl/cmp_toggle_gen.sv
module cmp_toggle_gen
  import cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [N_CH-1:0]       en_i,
  input  logic [N_CH*CNT_W-1:0] incr_i,
  input  logic [N_CH-1:0]       wr_lo_i,
  input  logic [N_CH-1:0]       wr_hi_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  input  logic [N_CH-1:0]       flag_clr_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [N_CH-1:0]       wave_o,
  output logic [N_CH-1:0]       flag_o
);
  logic [CNT_W-1:0] cnt;

  cmp_free_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    byte_wr_t wr;
    assign wr.lo = wr_lo_i[c];
    assign wr.hi = wr_hi_i[c];

    cmp_channel #(.W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .cnt_i      (cnt),
      .en_i       (en_i[c]),
      .incr_i     (incr_i[CNT_W*c +: CNT_W]),
      .wr_i       (wr),
      .wr_data_i  (wr_data_i),
      .flag_clr_i (flag_clr_i[c]),
      .wave_o     (wave_o[c]),
      .flag_o     (flag_o[c])
    );
  end

  assign cnt_o = cnt;
endmodule

// File: tb/cmp_toggle_gen_test.sv
module cmp_toggle_gen_test;
  localparam int W = 16;
  localparam int N = 2;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b0;
  logic [N-1:0]   en_i = '0;
  logic [N*W-1:0] incr_i = '0;
  logic [N-1:0]   wr_lo_i = '0, wr_hi_i = '0, flag_clr_i = '0;
  logic [7:0]     wr_data_i = '0;
  logic [W-1:0]   cnt_o;
  logic [N-1:0]   wave_o, flag_o;

  always #2 clk = ~clk;  // 250 MHz

  cmp_toggle_gen #(.CNT_W(W), .N_CH(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .incr_i(incr_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i),
    .wr_data_i(wr_data_i), .flag_clr_i(flag_clr_i),
    .cnt_o(cnt_o), .wave_o(wave_o), .flag_o(flag_o)
  );

  int    vecs = 0, errs = 0, cyc = 0;
  string cur_req = "R8";
  int    m_cnt = 0;
  int    m_cmp[N], m_wave[N], m_flag[N], m_lock[N], m_tog[N];

  // behavioural reference, updated at each edge from the inputs applied
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0;
      for (int c = 0; c < N; c++) begin
        m_wave[c] = 0; m_flag[c] = 0; m_lock[c] = 0;
      end
    end else begin
      for (int c = 0; c < N; c++) begin
        bit m;
        m = tick_i && en_i[c] && m_lock[c] == 0 && !wr_lo_i[c] && !wr_hi_i[c]
            && m_cnt == m_cmp[c];
        if (m) begin
          m_wave[c] = 1 - m_wave[c];
          m_flag[c] = 1;
          m_tog[c]++;
          m_cmp[c] = (m_cmp[c] + int'(incr_i[W*c +: W])) % 65536;
        end else if (flag_clr_i[c]) m_flag[c] = 0;
        if (wr_lo_i[c]) begin
          m_cmp[c] = (m_cmp[c] / 256) * 256 + int'(wr_data_i);
          m_lock[c] = 1;
        end
        if (wr_hi_i[c]) begin
          m_cmp[c] = (m_cmp[c] % 256) + 256 * int'(wr_data_i);
          m_lock[c] = 0;
        end
      end
      if (tick_i) m_cnt = (m_cnt + 1) % 65536;
    end
  end

  always @(negedge clk) begin
    vecs++;
    if (int'(cnt_o) != m_cnt) begin
      errs++;
      $display("FAIL %s/R1 cyc %0d cnt_o act %0h exp %0h", cur_req, cyc, cnt_o, m_cnt);
    end
    for (int c = 0; c < N; c++) begin
      if (int'(wave_o[c]) != m_wave[c]) begin
        errs++;
        $display("FAIL %s/R2 cyc %0d wave_o[%0d] act %0d exp %0d", cur_req, cyc, c, wave_o[c], m_wave[c]);
      end
      if (int'(flag_o[c]) != m_flag[c]) begin
        errs++;
        $display("FAIL %s/R5 cyc %0d flag_o[%0d] act %0d exp %0d", cur_req, cyc, c, flag_o[c], m_flag[c]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      errs++;
      $display("FAIL watchdog expired act %0d cycles exp below 190000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_incr(int c, int v);
    incr_i[W*c +: W] = W'(v);
  endtask

  task automatic load_cmp(int c, int v);
    wr_data_i = 8'(v % 256); wr_lo_i[c] = 1'b1; step(1);
    wr_lo_i[c] = 1'b0; wr_data_i = 8'(v / 256); wr_hi_i[c] = 1'b1; step(1);
    wr_hi_i[c] = 1'b0;
  endtask

  task automatic chk_int(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin m_cmp[c] = 0; m_tog[c] = 0; end
    // R8: reset state held
    step(4);
    rst_ni = 1'b1;
    step(3);

    // R1 R3: 400 Hz tone and 125x filter clock, one full counter wrap
    cur_req = "R3";
    load_cmp(0, 100); load_cmp(1, 100);
    set_incr(0, 2562); set_incr(1, 20);
    en_i = 2'b11; tick_i = 1'b1;
    for (int c = 0; c < N; c++) m_tog[c] = 0;
    step(66000);
    // 125x ratio: R3 toggle counts, 66000 ticks from 100
    chk_int("R3 tone toggles", m_tog[0], (66000 - 1 - 100) / 2562 + 1);
    chk_int("R3 filter toggles", m_tog[1], (66000 - 1 - 100) / 20 + 1);

    // R4: change increments mid half-period (600 Hz set)
    cur_req = "R4";
    step(37); set_incr(0, 1708); set_incr(1, 14);
    step(4000);

    // R9: sparse ticks, increment 1 toggles once per held counter value
    cur_req = "R9";
    load_cmp(1, int'(cnt_o) + 3); set_incr(1, 1);
    for (int i = 0; i < 300; i++) begin
      tick_i = (i % 5 == 0); step(1);
    end
    tick_i = 1'b1;

    // R6: channel 1 disabled, output frozen
    cur_req = "R6";
    en_i[1] = 1'b0; step(200); en_i[1] = 1'b1;

    // R7: low byte written, counter sweeps past old compare, then high byte
    cur_req = "R7";
    set_incr(0, 9);
    load_cmp(0, int'(cnt_o) + 5);
    wr_data_i = 8'h00; wr_lo_i[0] = 1'b1; step(1); wr_lo_i[0] = 1'b0;
    step(400);
    wr_data_i = 8'(int'(cnt_o) / 256 + 1); wr_hi_i[0] = 1'b1; step(1); wr_hi_i[0] = 1'b0;
    step(600);

    // R5: flag clears, including clears colliding with matches
    cur_req = "R5";
    set_incr(0, 3); set_incr(1, 2);
    for (int i = 0; i < 400; i++) begin
      flag_clr_i = 2'(i % 4 == 0 ? 2'b11 : (i % 7 == 0 ? 2'b01 : 2'b00));
      step(1);
    end
    flag_clr_i = '0;

    // R2: mixed random traffic
    cur_req = "R2";
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = int'($urandom % 100);
      tick_i = ($urandom % 3) != 0;
      en_i = 2'($urandom % 4 != 0 ? 2'b11 : $urandom % 4);
      flag_clr_i = 2'($urandom % 4);
      if (r < 2) set_incr(int'($urandom % 2), int'($urandom % 40) + 1);
      if (r == 5) begin
        wr_data_i = 8'($urandom); wr_lo_i[$urandom % 2] = 1'b1;
      end else if (r == 6) begin
        wr_data_i = 8'(int'(cnt_o) / 256); wr_hi_i[$urandom % 2] = 1'b1;
      end
      step(1);
      wr_lo_i = '0; wr_hi_i = '0;
    end

    // R8: reset in mid-run
    cur_req = "R8";
    @(posedge clk); #1 rst_ni = 1'b0;
    step(2);
    chk_int("R8 wave after reset", int'(wave_o), 0);
    chk_int("R8 flag after reset", int'(flag_o), 0);
    chk_int("R8 cnt after reset", int'(cnt_o), 0);
    rst_ni = 1'b1; step(5);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule